// File: doc/BRIEF.md
# Field/Frame Capture Base-Address Selector

This block chooses the memory start address of each plane of captured video for the write engine that follows it. The choice depends on a two-bit addressing mode, the parity of the field being captured, and, for double buffering, a frame selector that alternates between two frames. Six programmable base registers feed the selection. A byte offset is added only in the double-buffered mode. The block also passes on a byte-swap request that sets the byte order of the output.

All results are captured on a field-start strobe while capture is enabled. They then stay fixed for the whole field, however the programming inputs move. In double-buffered mode the block steps through four buffer slots: frame A odd, frame A even, frame B odd, frame B even. The frame selector advances only when an even field closes, so the next odd field lands in the other frame. Dropping capture enable returns the selector to frame A.

Top module: `fbsel_top`

## Requirements
- R1: While reset is high and on the first cycle after it, every plane address reads 0. The plane valids, the frame selector, the byte-swap output and the error flag are also 0.
- R2: Outputs load on a clock edge where field_start_i and cap_en_i are both 1, and hold at every other edge. The one exception is that the plane valids clear on the edge after cap_en_i is sampled low. The addresses hold in that case.
- R3: Mode 2'b00 uses one address set: plane p takes base p (base index 0 is the first register). plane_cnt_i gives the number of active planes: 0 means 1, 1 means 2, 2 or 3 means 3. Inactive planes read address 0 with valid 0, so the valids always form a run of ones starting at bit 0.
- R4: Mode 2'b10 alternates by field. When field_odd_i is 1, plane p takes base p. When it is 0, plane p takes base p+3. Planes are activated as in R3.
- R5: Mode 2'b11 drives plane 0 only, valid 1, with address base[2*frame_sel + (field_odd_i ? 0 : 1)] + offset_i. The offset is zero-extended and the sum wraps modulo 2^ADDR_W. Planes 1 and 2 read 0 with valid 0 whatever plane_cnt_i is.
- R6: The reserved mode 2'b01 sets mode_err_o at the field start where it is loaded and otherwise behaves as mode 2'b00. The flag clears at the next field start loaded with another mode.
- R7: frame_sel_o is 0 on the edge after cap_en_i is sampled low.
- R8: frame_sel_o inverts on an edge where field_end_i and cap_en_i are 1 and the loaded field is valid, even and in mode 2'b11. It holds on every other enabled edge. A field start on the same edge uses the value from before the inversion.
- R9: byte_swap_o loads swap_cfg_i at each accepted field start (0 keeps system byte order, 1 reverses it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 6 x ADDR_W | Six base-address registers |
| offset_i | input | OFF_W | Byte offset for double-buffered mode |
| mode_i | input | 2 | Addressing mode |
| plane_cnt_i | input | 2 | Active plane count code |
| swap_cfg_i | input | 1 | Requested output byte order |
| cap_en_i | input | 1 | Capture enable |
| field_odd_i | input | 1 | Parity of the starting field (1 = odd) |
| field_start_i | input | 1 | Field-start strobe |
| field_end_i | input | 1 | Field-end strobe |
| plane_addr_o | output | 3 x ADDR_W | Plane base addresses |
| plane_vld_o | output | 3 | Plane valid flags |
| frame_sel_o | output | 1 | Current frame (0 = frame A, 1 = frame B) |
| byte_swap_o | output | 1 | Byte-swap control |
| mode_err_o | output | 1 | Reserved mode loaded |

## Verification
The hardest case to reach is the fourth slot of double buffering, frame B even. It needs capture held on through a complete even field, an odd field in the second frame, and then another even field start, all in mode 2'b11. The directed stimulus walks through that sequence and past the wrap back to frame A. It then repeats the walk with a field end and the next field start on the same edge, and with capture dropped partway, to check the selector clear. A long random phase with sparse strobes follows, compared on every clock against a behavioural model.

// File: rtl/fbsel_pkg.sv
package fbsel_pkg;
    parameter int ADDR_W = 32;
    parameter int OFF_W  = 16;
    parameter int NPLANE = 3;
    parameter int NBASE  = 2 * NPLANE;
    localparam int SLOT_W = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef enum logic [1:0] {
        AM_SINGLE = 2'b00,
        AM_RSVD   = 2'b01,
        AM_FIELD  = 2'b10,
        AM_DBUF   = 2'b11
    } amode_e;

    typedef struct packed {
        addr_t [NPLANE-1:0] addr;
        logic  [NPLANE-1:0] vld;
    } plane_set_t;

    // Thermometer mask of active planes from the count code.
    function automatic logic [NPLANE-1:0] plane_mask(input logic [1:0] cnt);
        logic [NPLANE-1:0] m;
        for (int p = 0; p < NPLANE; p++) begin
            m[p] = (p <= int'(cnt));
        end
        return m;
    endfunction

    // Slot within the four double-buffer entries.
    function automatic logic [SLOT_W-1:0] dbuf_slot(input logic fsel, input logic odd);
        return {fsel, ~odd};
    endfunction
endpackage

// File: rtl/fbsel_addr_mux.sv
module fbsel_addr_mux
    import fbsel_pkg::*;
(
    input  addr_t [NBASE-1:0] base_i,
    input  off_t              offset_i,
    input  amode_e            mode_i,
    input  logic [1:0]        plane_cnt_i,
    input  logic              field_odd_i,
    input  logic              frame_sel_i,
    output plane_set_t        set_o
);
    logic [NPLANE-1:0] mask;
    addr_t             dbuf_addr;

    assign mask      = plane_mask(plane_cnt_i);
    assign dbuf_addr = base_i[dbuf_slot(frame_sel_i, field_odd_i)]
                     + addr_t'(offset_i);

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        always_comb begin
            set_o.addr[p] = '0;
            set_o.vld[p]  = 1'b0;
            unique case (mode_i)
                AM_SINGLE, AM_RSVD: begin
                    set_o.vld[p]  = mask[p];
                    set_o.addr[p] = mask[p] ? base_i[p] : '0;
                end
                AM_FIELD: begin
                    set_o.vld[p]  = mask[p];
                    if (mask[p]) begin
                        set_o.addr[p] = field_odd_i ? base_i[p] : base_i[p+NPLANE];
                    end
                end
                AM_DBUF: begin
                    if (p == 0) begin
                        set_o.vld[p]  = 1'b1;
                        set_o.addr[p] = dbuf_addr;
                    end
                end
                default: begin
                    set_o.vld[p]  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fbsel_frame_seq.sv
module fbsel_frame_seq
    import fbsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cap_en_i,
    input  logic   field_end_i,
    input  logic   active_i,
    input  amode_e mode_q_i,
    input  logic   odd_q_i,
    output logic   frame_sel_o
);
    logic step;

    assign step = field_end_i && active_i && (mode_q_i == AM_DBUF) && !odd_q_i;

    always_ff @(posedge clk) begin
        if (rst || !cap_en_i) begin
            frame_sel_o <= 1'b0;
        end else if (step) begin
            frame_sel_o <= ~frame_sel_o;
        end
    end

    AST_FSEL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !cap_en_i |=> !frame_sel_o); // R7
    AST_FSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cap_en_i && !field_end_i) |=> $stable(frame_sel_o)); // R8
endmodule

// File: rtl/fbsel_out_reg.sv
module fbsel_out_reg
    import fbsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_en_i,
    input  logic       field_start_i,
    input  plane_set_t set_d_i,
    input  amode_e     mode_i,
    input  logic       field_odd_i,
    input  logic       swap_cfg_i,
    output plane_set_t set_q_o,
    output amode_e     mode_q_o,
    output logic       odd_q_o,
    output logic       err_q_o,
    output logic       swap_q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            set_q_o  <= '0;
            mode_q_o <= AM_SINGLE;
            odd_q_o  <= 1'b0;
            err_q_o  <= 1'b0;
            swap_q_o <= 1'b0;
        end else if (!cap_en_i) begin
            set_q_o.vld <= '0;
        end else if (field_start_i) begin
            set_q_o  <= set_d_i;
            mode_q_o <= mode_i;
            odd_q_o  <= field_odd_i;
            err_q_o  <= (mode_i == AM_RSVD);
            swap_q_o <= swap_cfg_i;
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(field_start_i && cap_en_i) |=> $stable(set_q_o.addr)); // R2
    AST_VLD_RUN: assert property (@(posedge clk) disable iff (rst)
        ((set_q_o.vld & (set_q_o.vld + 1'b1)) == '0)); // R3
    AST_DBUF_ONE_PLANE: assert property (@(posedge clk) disable iff (rst)
        (set_q_o.vld[0] && mode_q_o == AM_DBUF) |->
            (set_q_o.vld[NPLANE-1:1] == '0 && set_q_o.addr[NPLANE-1:1] == '0)); // R5
    AST_ERR_MATCH: assert property (@(posedge clk) disable iff (rst)
        err_q_o |-> (mode_q_o == AM_RSVD)); // R6
endmodule

// File: rtl/fbsel_top.sv
module fbsel_top
    import fbsel_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NBASE-1:0][ADDR_W-1:0]   base_i,
    input  logic [OFF_W-1:0]               offset_i,
    input  logic [1:0]                     mode_i,
    input  logic [1:0]                     plane_cnt_i,
    input  logic                           swap_cfg_i,
    input  logic                           cap_en_i,
    input  logic                           field_odd_i,
    input  logic                           field_start_i,
    input  logic                           field_end_i,
    output logic [NPLANE-1:0][ADDR_W-1:0]  plane_addr_o,
    output logic [NPLANE-1:0]              plane_vld_o,
    output logic                           frame_sel_o,
    output logic                           byte_swap_o,
    output logic                           mode_err_o
);
    plane_set_t set_d;
    plane_set_t set_q;
    amode_e     mode_live;
    amode_e     mode_q;
    logic       odd_q;
    logic       fsel;

    assign mode_live = amode_e'(mode_i);

    fbsel_addr_mux u_mux (
        .base_i      (base_i),
        .offset_i    (offset_i),
        .mode_i      (mode_live),
        .plane_cnt_i (plane_cnt_i),
        .field_odd_i (field_odd_i),
        .frame_sel_i (fsel),
        .set_o       (set_d)
    );

    fbsel_out_reg u_out (
        .clk           (clk),
        .rst           (rst),
        .cap_en_i      (cap_en_i),
        .field_start_i (field_start_i),
        .set_d_i       (set_d),
        .mode_i        (mode_live),
        .field_odd_i   (field_odd_i),
        .swap_cfg_i    (swap_cfg_i),
        .set_q_o       (set_q),
        .mode_q_o      (mode_q),
        .odd_q_o       (odd_q),
        .err_q_o       (mode_err_o),
        .swap_q_o      (byte_swap_o)
    );

    fbsel_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cap_en_i    (cap_en_i),
        .field_end_i (field_end_i),
        .active_i    (set_q.vld[0]),
        .mode_q_i    (mode_q),
        .odd_q_i     (odd_q),
        .frame_sel_o (fsel)
    );

    assign plane_addr_o = set_q.addr;
    assign plane_vld_o  = set_q.vld;
    assign frame_sel_o  = fsel;
endmodule

// File: tb/test_fbsel_top.sv
module test_fbsel_top;
    localparam int AW = 32;
    localparam int OW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0][AW-1:0] base;
    logic [OW-1:0] offset;
    logic [1:0] mode, pcnt;
    logic swap, cap, odd, fstart, fend;
    logic [2:0][AW-1:0] addr;
    logic [2:0] vld;
    logic fsel, bswap, err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fbsel_top i_fbsel_top (
        .clk(clk), .rst(rst), .base_i(base), .offset_i(offset), .mode_i(mode),
        .plane_cnt_i(pcnt), .swap_cfg_i(swap), .cap_en_i(cap), .field_odd_i(odd),
        .field_start_i(fstart), .field_end_i(fend), .plane_addr_o(addr),
        .plane_vld_o(vld), .frame_sel_o(fsel), .byte_swap_o(bswap), .mode_err_o(err)
    );

    // Behavioural reference state
    logic [AW-1:0] m_addr [3];
    bit m_vld [3];
    int m_mode = 0;
    bit m_odd = 0, m_fsel = 0, m_swap = 0, m_err = 0, m_first = 1;

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 3; p++) begin m_addr[p] = '0; m_vld[p] = 0; end
            m_mode = 0; m_odd = 0; m_fsel = 0; m_swap = 0; m_err = 0;
        end else begin
            bit nf;
            nf = m_fsel;
            if (!cap) nf = 0;
            else if (fend && m_vld[0] && m_mode == 3 && !m_odd) nf = !m_fsel;
            if (!cap) begin
                for (int p = 0; p < 3; p++) m_vld[p] = 0;
            end else if (fstart) begin
                int n;
                n = (pcnt == 0) ? 1 : (pcnt == 1) ? 2 : 3;
                for (int p = 0; p < 3; p++) begin
                    m_addr[p] = '0; m_vld[p] = 0;
                    if (mode == 3) begin
                        if (p == 0) begin
                            m_addr[0] = base[2 * int'(m_fsel) + (odd ? 0 : 1)] + {16'h0, offset};
                            m_vld[0] = 1;
                        end
                    end else if (p < n) begin
                        m_vld[p] = 1;
                        m_addr[p] = (mode == 2 && !odd) ? base[p + 3] : base[p];
                    end
                end
                m_mode = int'(mode); m_odd = odd; m_swap = swap; m_err = (mode == 1);
            end
            m_fsel = nf;
        end
    end

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input int m);
        return (m == 0) ? "R3" : (m == 1) ? "R6" : (m == 2) ? "R4" : "R5";
    endfunction

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            for (int p = 0; p < 3; p++) begin
                chk({mode_tag(m_mode), " addr"}, addr[p], m_addr[p]);
                chk({mode_tag(m_mode), " vld"}, AW'(vld[p]), AW'(m_vld[p]));
            end
            chk("R8 frame_sel", AW'(fsel), AW'(m_fsel));
            chk("R9 byte_swap", AW'(bswap), AW'(m_swap));
            chk("R6 mode_err", AW'(err), AW'(m_err));
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_field(input bit o, input int len);
        odd = o; fstart = 1; step(); fstart = 0;
        step(len);
        fend = 1; step(); fend = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        base[0] = 32'h1000_0000; base[1] = 32'h1100_0000; base[2] = 32'h1200_0000;
        base[3] = 32'hFFFF_FFF0; base[4] = 32'h2100_0000; base[5] = 32'h2200_0000;
        offset = 16'h0040; mode = 0; pcnt = 0; swap = 0; cap = 0; odd = 1;
        fstart = 0; fend = 0;
        step(4);
        // R1: reset state
        chk("R1 vld", AW'(vld), '0);
        chk("R1 addr0", addr[0], '0);
        rst = 0; step();
        chk("R1 after release", {AW'(vld), 29'(0), fsel, bswap, err}, '0);

        cap = 1;
        for (int c = 0; c < 4; c++) begin
            pcnt = 2'(c); run_field(1, 3);       // R3 plane counts
        end
        // R2: programming changes mid-field are not seen
        pcnt = 2; mode = 0; odd = 1; fstart = 1; step(); fstart = 0;
        base[1] = 32'hDEAD_0000; mode = 2; swap = 1; step(2);
        chk("R2 hold addr1", addr[1], 32'h1100_0000);
        chk("R2 hold swap", AW'(bswap), '0);
        fend = 1; step(); fend = 0;
        base[1] = 32'h1100_0000;
        run_field(1, 2); run_field(0, 2);        // R4 odd / even sets, R9 swap
        mode = 1; run_field(1, 2);               // R6 reserved mode
        chk("R6 err set", AW'(err), 1);
        mode = 0; run_field(0, 2);
        chk("R6 err cleared", AW'(err), 0);

        // R5 / R8: full double-buffer walk, including wrap
        mode = 3; pcnt = 3;
        run_field(1, 2); run_field(0, 2); run_field(1, 2); run_field(0, 2);
        chk("R8 wrapped", AW'(fsel), 0);
        run_field(1, 2);
        chk("R8 odd end no step", AW'(fsel), 0);
        odd = 0; fstart = 1; step(); fstart = 0; step(2);
        fend = 1; fstart = 1; odd = 1; step(); fend = 0; fstart = 0;  // same-edge end/start
        chk("R8 same edge uses old frame", addr[0], base[0] + 32'h40);
        chk("R8 stepped", AW'(fsel), 1);
        offset = 16'h0020; run_field(0, 2);
        chk("R5 wrap modulo", addr[0], base[3] + 32'h20);
        // R7: disabling clears the frame
        cap = 0; step();
        chk("R7 frame cleared", AW'(fsel), 0);
        chk("R2 valid cleared", AW'(vld), 0);
        step(2); cap = 1;

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            mode = 2'($urandom); pcnt = 2'($urandom); swap = 1'($urandom);
            odd = 1'($urandom); offset = 16'($urandom);
            base[$urandom % 6] = $urandom;
            cap = ($urandom % 40) != 0;
            fstart = ($urandom % 6) == 0;
            fend = ($urandom % 5) == 0;
            if (($urandom % 500) == 0) rst = 1; else rst = 0;
            step();
        end
        rst = 0; fstart = 0; fend = 0; step(2);
        finish_run();
    end
endmodule